// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, once per clock, which hardware threads of a simultaneous multithreading front end may fetch instructions, and how the fetch width is divided among them. It keeps three saturating per-thread counters: instructions in flight between decode and the issue queues, unresolved branches, and outstanding data-cache misses. Up and down strobes from the rest of the pipeline drive these counters. It also receives, for each thread, how far that thread's oldest entry sits from the head of the integer and floating-point issue queues.

A 3-bit policy code is sampled at every clock edge. It selects the ranking key: plain rotation, fewest in-flight instructions, fewest unresolved branches, fewest outstanding misses, or queue position. Under queue position, a thread whose oldest entry is close to a queue head ranks worst. The two best eligible threads are chosen. Equal keys are ordered by a rotating pointer. The first thread gets its requested slot count, capped at the fetch width, and the second thread gets what is left. All outputs are registered.

Top module: `smt_fetch_sel`

## Requirements
- R1: A synchronous active-high reset clears all counters, sets the rotation pointer to thread 0, and leaves both selection outputs invalid with zero thread IDs and zero slots.
- R2: Each counter rises by one on its allocate strobe and falls by one on its leave strobe. Both strobes in the same cycle leave it unchanged. It holds at 63 on a further increment and at 0 on a further decrement.
- R3: A thread whose eligibility bit is low is never selected, and the two selected thread IDs always differ. With no eligible thread, both valid outputs are low and the rotation pointer holds.
- R4: With exactly one eligible thread, that thread is reported as the first selection with 8 slots, and the second valid output is low.
- R5: With two or more eligible threads, the first thread receives min(request, 8) slots and the second receives 8 minus that amount. The second valid output is low when that remainder is 0.
- R6: Policy codes 0, 5, 6 and 7 rank all eligible threads equally, so the choice follows the rotation order alone.
- R7: Policy code 1 prefers the thread with the smallest in-flight instruction count.
- R8: Policy code 2 prefers the thread with the fewest unresolved branches.
- R9: Policy code 3 prefers the thread with the fewest outstanding data-cache misses.
- R10: Policy code 4 prefers the thread with the largest value of min(integer-queue distance, FP-queue distance). A distance of 0 means the thread's oldest entry is at the queue head.
- R11: Equal keys are ordered starting from the rotation pointer (pointer, pointer+1, ... modulo 4). The pointer advances by one in every cycle in which at least one thread is selected.
- R12: The outputs after clock edge k reflect the policy code, mask, requests, positions and counter values present just before edge k. A counter strobe affects the selection from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pol_sel | input | 3 | Ranking policy code |
| elig_mask | input | 4 | Per-thread fetch eligibility (1 = may fetch) |
| infl_alloc | input | 4 | Per-thread in-flight count increment |
| infl_leave | input | 4 | Per-thread in-flight count decrement |
| br_alloc | input | 4 | Per-thread unresolved-branch increment |
| br_leave | input | 4 | Per-thread unresolved-branch decrement |
| miss_alloc | input | 4 | Per-thread outstanding-miss increment |
| miss_leave | input | 4 | Per-thread outstanding-miss decrement |
| iq_int_pos | input | 20 | Per-thread 5-bit distance of oldest entry from integer queue head |
| iq_fp_pos | input | 20 | Per-thread 5-bit distance of oldest entry from FP queue head |
| slot_req | input | 16 | Per-thread 4-bit requested fetch slot count |
| f0_vld | output | 1 | First selection valid |
| f0_tid | output | 2 | First selected thread |
| f0_slots | output | 4 | Slots given to first thread |
| f1_vld | output | 1 | Second selection valid |
| f1_tid | output | 2 | Second selected thread |
| f1_slots | output | 4 | Slots given to second thread |

## Verification
The properties assume that the eligibility mask, the requests and the strobes are known values after reset. They also assume the pipeline may raise allocate and leave strobes together for the same thread. The stimulus drives all inputs on the falling edge from a random source, so every input is defined throughout. It deliberately pushes counters past 63 and below 0, so the saturation checks are exercised rather than assumed away. Requests above 8 are also generated, so the capping of the first thread's share is exercised against the slot-sum property.

// File: rtl/smt_fetch_pkg.sv
`timescale 1ns/1ps
package smt_fetch_pkg;

    typedef enum logic [2:0] {
        POL_ROTATE = 3'd0,
        POL_INFL   = 3'd1,
        POL_BRANCH = 3'd2,
        POL_MISS   = 3'd3,
        POL_QPOS   = 3'd4
    } policy_e;

    // Codes outside the defined set fall back to plain rotation.
    function automatic policy_e pol_decode(input logic [2:0] code);
        policy_e p;
        case (code)
            3'd1:    p = POL_INFL;
            3'd2:    p = POL_BRANCH;
            3'd3:    p = POL_MISS;
            3'd4:    p = POL_QPOS;
            default: p = POL_ROTATE;
        endcase
        return p;
    endfunction

    // Saturating up/down step; simultaneous strobes cancel.
    function automatic int unsigned ctr_next(input int unsigned v,
                                             input logic up,
                                             input logic dn,
                                             input int unsigned vmax);
        int unsigned r;
        r = v;
        if (up && !dn && v < vmax) r = v + 1;
        if (dn && !up && v > 0)    r = v - 1;
        return r;
    endfunction

endpackage

// File: rtl/smt_fetch_ctr.sv
`timescale 1ns/1ps
module smt_fetch_ctr #(
    parameter int NT = 4,
    parameter int W  = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NT-1:0]   up,
    input  logic [NT-1:0]   dn,
    output logic [NT*W-1:0] cnt
);
    import smt_fetch_pkg::*;

    localparam int unsigned VMAX = (1 << W) - 1;

    logic [W-1:0] c_q [NT];

    for (genvar t = 0; t < NT; t++) begin : g_thr
        always_ff @(posedge clk) begin
            if (rst) begin
                c_q[t] <= '0;
            end else begin
                c_q[t] <= W'(ctr_next(int'(c_q[t]), up[t], dn[t], VMAX));
            end
        end
        assign cnt[t*W +: W] = c_q[t];
    end

endmodule

// File: rtl/smt_fetch_key.sv
`timescale 1ns/1ps
module smt_fetch_key #(
    parameter int NT    = 4,
    parameter int CNT_W = 6,
    parameter int POS_W = 5,
    parameter int KEY_W = 6
) (
    input  logic [2:0]          pol_code,
    input  logic [NT*CNT_W-1:0] infl_cnt,
    input  logic [NT*CNT_W-1:0] br_cnt,
    input  logic [NT*CNT_W-1:0] miss_cnt,
    input  logic [NT*POS_W-1:0] int_pos,
    input  logic [NT*POS_W-1:0] fp_pos,
    output logic [NT*KEY_W-1:0] key
);
    import smt_fetch_pkg::*;

    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    policy_e pol;
    assign pol = pol_decode(pol_code);

    for (genvar t = 0; t < NT; t++) begin : g_key
        logic [POS_W-1:0] near;
        logic [POS_W-1:0] ip;
        logic [POS_W-1:0] fp;
        assign ip   = int_pos[t*POS_W +: POS_W];
        assign fp   = fp_pos[t*POS_W +: POS_W];
        // Closest approach to either queue head; nearer means worse rank.
        assign near = (ip < fp) ? ip : fp;

        always_comb begin
            case (pol)
                POL_INFL:   key[t*KEY_W +: KEY_W] = KEY_W'(infl_cnt[t*CNT_W +: CNT_W]);
                POL_BRANCH: key[t*KEY_W +: KEY_W] = KEY_W'(br_cnt[t*CNT_W +: CNT_W]);
                POL_MISS:   key[t*KEY_W +: KEY_W] = KEY_W'(miss_cnt[t*CNT_W +: CNT_W]);
                POL_QPOS:   key[t*KEY_W +: KEY_W] = KEY_W'(POS_MAX - near);
                default:    key[t*KEY_W +: KEY_W] = '0;
            endcase
        end
    end

endmodule

// File: rtl/smt_fetch_pick.sv
`timescale 1ns/1ps
module smt_fetch_pick #(
    parameter int NT    = 4,
    parameter int TID_W = 2,
    parameter int KEY_W = 6
) (
    input  logic [NT-1:0]       elig,
    input  logic [NT*KEY_W-1:0] key,
    input  logic [TID_W-1:0]    ptr,
    output logic                v0,
    output logic [TID_W-1:0]    t0,
    output logic                v1,
    output logic [TID_W-1:0]    t1
);
    // Scan in rotation order from ptr; a strict compare keeps the
    // earliest thread in that order when keys are equal.
    always_comb begin
        logic [TID_W-1:0] t;
        logic [KEY_W-1:0] best0;
        logic [KEY_W-1:0] best1;
        logic [KEY_W-1:0] k;
        v0 = 1'b0; t0 = '0; best0 = '0;
        v1 = 1'b0; t1 = '0; best1 = '0;
        for (int o = 0; o < NT; o++) begin
            t = ptr + TID_W'(o);
            k = key[t*KEY_W +: KEY_W];
            if (elig[t] && (!v0 || k < best0)) begin
                v0    = 1'b1;
                t0    = t;
                best0 = k;
            end
        end
        for (int o = 0; o < NT; o++) begin
            t = ptr + TID_W'(o);
            k = key[t*KEY_W +: KEY_W];
            if (elig[t] && !(v0 && t == t0) && (!v1 || k < best1)) begin
                v1    = 1'b1;
                t1    = t;
                best1 = k;
            end
        end
    end

endmodule

// File: rtl/smt_fetch_sel.sv
`timescale 1ns/1ps
module smt_fetch_sel #(
    parameter  int NT      = 4,
    parameter  int CNT_W   = 6,
    parameter  int POS_W   = 5,
    parameter  int FETCH_W = 8,
    localparam int TID_W   = $clog2(NT),
    localparam int SLOT_W  = $clog2(FETCH_W + 1),
    localparam int KEY_W   = (CNT_W > POS_W) ? CNT_W : POS_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          pol_sel,
    input  logic [NT-1:0]       elig_mask,
    input  logic [NT-1:0]       infl_alloc,
    input  logic [NT-1:0]       infl_leave,
    input  logic [NT-1:0]       br_alloc,
    input  logic [NT-1:0]       br_leave,
    input  logic [NT-1:0]       miss_alloc,
    input  logic [NT-1:0]       miss_leave,
    input  logic [NT*POS_W-1:0] iq_int_pos,
    input  logic [NT*POS_W-1:0] iq_fp_pos,
    input  logic [NT*SLOT_W-1:0] slot_req,
    output logic                f0_vld,
    output logic [TID_W-1:0]    f0_tid,
    output logic [SLOT_W-1:0]   f0_slots,
    output logic                f1_vld,
    output logic [TID_W-1:0]    f1_tid,
    output logic [SLOT_W-1:0]   f1_slots
);
    localparam logic [SLOT_W-1:0] FULL = SLOT_W'(FETCH_W);

    logic [NT*CNT_W-1:0] infl_cnt;
    logic [NT*CNT_W-1:0] br_cnt;
    logic [NT*CNT_W-1:0] miss_cnt;
    logic [NT*KEY_W-1:0] key;
    logic [TID_W-1:0]    ptr_q;
    logic                pv0, pv1;
    logic [TID_W-1:0]    pt0, pt1;
    logic [SLOT_W-1:0]   req0, share0, s0_d, s1_d;
    logic                v1_d;

    smt_fetch_ctr #(.NT(NT), .W(CNT_W)) u_infl (
        .clk(clk), .rst(rst), .up(infl_alloc), .dn(infl_leave), .cnt(infl_cnt));
    smt_fetch_ctr #(.NT(NT), .W(CNT_W)) u_br (
        .clk(clk), .rst(rst), .up(br_alloc), .dn(br_leave), .cnt(br_cnt));
    smt_fetch_ctr #(.NT(NT), .W(CNT_W)) u_miss (
        .clk(clk), .rst(rst), .up(miss_alloc), .dn(miss_leave), .cnt(miss_cnt));

    smt_fetch_key #(.NT(NT), .CNT_W(CNT_W), .POS_W(POS_W), .KEY_W(KEY_W)) u_key (
        .pol_code(pol_sel), .infl_cnt(infl_cnt), .br_cnt(br_cnt), .miss_cnt(miss_cnt),
        .int_pos(iq_int_pos), .fp_pos(iq_fp_pos), .key(key));

    smt_fetch_pick #(.NT(NT), .TID_W(TID_W), .KEY_W(KEY_W)) u_pick (
        .elig(elig_mask), .key(key), .ptr(ptr_q),
        .v0(pv0), .t0(pt0), .v1(pv1), .t1(pt1));

    // Request-limited split of the fetch width.
    always_comb begin
        req0   = slot_req[pt0*SLOT_W +: SLOT_W];
        share0 = (req0 > FULL) ? FULL : req0;
        if (pv1) begin
            s0_d = share0;
            s1_d = FULL - share0;
        end else begin
            s0_d = FULL;
            s1_d = '0;
        end
        v1_d = pv1 && (s1_d != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q    <= '0;
            f0_vld   <= 1'b0;
            f0_tid   <= '0;
            f0_slots <= '0;
            f1_vld   <= 1'b0;
            f1_tid   <= '0;
            f1_slots <= '0;
        end else begin
            if (pv0) ptr_q <= ptr_q + 1'b1;
            f0_vld   <= pv0;
            f0_tid   <= pv0 ? pt0 : '0;
            f0_slots <= pv0 ? s0_d : '0;
            f1_vld   <= v1_d;
            f1_tid   <= v1_d ? pt1 : '0;
            f1_slots <= v1_d ? s1_d : '0;
        end
    end

endmodule

// File: rtl/smt_fetch_sel_chk.sv
`timescale 1ns/1ps
module smt_fetch_sel_chk #(
    parameter int NT      = 4,
    parameter int CNT_W   = 6,
    parameter int TID_W   = 2,
    parameter int SLOT_W  = 4,
    parameter int FETCH_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [NT-1:0]       elig_mask,
    input logic [NT-1:0]       infl_alloc,
    input logic [NT-1:0]       infl_leave,
    input logic [NT*CNT_W-1:0] infl_cnt,
    input logic                f0_vld,
    input logic [TID_W-1:0]    f0_tid,
    input logic [SLOT_W-1:0]   f0_slots,
    input logic                f1_vld,
    input logic [TID_W-1:0]    f1_tid,
    input logic [SLOT_W-1:0]   f1_slots
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!f0_vld && !f1_vld && f0_slots == '0 && f1_slots == '0));

    // R3
    masked_pick_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && f0_vld) |-> ((($past(elig_mask) >> f0_tid) & NT'(1)) != '0));

    // R3
    distinct_pick_chk: assert property (@(posedge clk) disable iff (rst)
        f1_vld |-> (f0_vld && f1_tid != f0_tid));

    // R3
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(elig_mask) == '0) |-> (!f0_vld && !f1_vld));

    // R4
    lone_thread_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $countones($past(elig_mask)) == 1)
            |-> (f0_vld && f0_slots == SLOT_W'(FETCH_W) && !f1_vld));

    // R5
    slot_sum_chk: assert property (@(posedge clk) disable iff (rst)
        f1_vld |-> (32'(f0_slots) + 32'(f1_slots) == FETCH_W && f1_slots != '0));

    for (genvar t = 0; t < NT; t++) begin : g_cnt
        // R2
        cancel_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (infl_alloc[t] && infl_leave[t]) |=> $stable(infl_cnt[t*CNT_W +: CNT_W]));
        // R2
        no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
            (infl_cnt[t*CNT_W +: CNT_W] == CMAX && infl_alloc[t] && !infl_leave[t])
                |=> (infl_cnt[t*CNT_W +: CNT_W] == CMAX));
        // R2
        no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
            (infl_cnt[t*CNT_W +: CNT_W] == '0 && infl_leave[t] && !infl_alloc[t])
                |=> (infl_cnt[t*CNT_W +: CNT_W] == '0));
    end

endmodule

bind smt_fetch_sel smt_fetch_sel_chk #(
    .NT(NT), .CNT_W(CNT_W), .TID_W(TID_W), .SLOT_W(SLOT_W), .FETCH_W(FETCH_W)
) u_chk (
    .clk(clk), .rst(rst), .elig_mask(elig_mask),
    .infl_alloc(infl_alloc), .infl_leave(infl_leave), .infl_cnt(infl_cnt),
    .f0_vld(f0_vld), .f0_tid(f0_tid), .f0_slots(f0_slots),
    .f1_vld(f1_vld), .f1_tid(f1_tid), .f1_slots(f1_slots)
);

// File: tb/sim_smt_fetch_sel.sv
`timescale 1ns/1ps
module sim_smt_fetch_sel;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  pol_sel;
    logic [3:0]  elig_mask;
    logic [3:0]  infl_alloc, infl_leave, br_alloc, br_leave, miss_alloc, miss_leave;
    logic [19:0] iq_int_pos, iq_fp_pos;
    logic [15:0] slot_req;
    logic        f0_vld, f1_vld;
    logic [1:0]  f0_tid, f1_tid;
    logic [3:0]  f0_slots, f1_slots;

    always #2 clk = ~clk;

    smt_fetch_sel u0 (
        .clk(clk), .rst(rst), .pol_sel(pol_sel), .elig_mask(elig_mask),
        .infl_alloc(infl_alloc), .infl_leave(infl_leave),
        .br_alloc(br_alloc), .br_leave(br_leave),
        .miss_alloc(miss_alloc), .miss_leave(miss_leave),
        .iq_int_pos(iq_int_pos), .iq_fp_pos(iq_fp_pos), .slot_req(slot_req),
        .f0_vld(f0_vld), .f0_tid(f0_tid), .f0_slots(f0_slots),
        .f1_vld(f1_vld), .f1_tid(f1_tid), .f1_slots(f1_slots));

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Behavioural reference state.
    int m_infl[4], m_br[4], m_miss[4];
    int m_ptr;
    int x0v, x0t, x0s, x1v, x1t, x1s;

    function automatic int bump(int v, bit up, bit dn);
        if (up == dn) return v;
        if (up) return (v == 63) ? 63 : v + 1;
        return (v == 0) ? 0 : v - 1;
    endfunction

    always @(posedge clk) begin : ref_model
        int key[4];
        int score[4];
        int first, second, want;
        if (rst) begin
            foreach (m_infl[i]) begin m_infl[i] = 0; m_br[i] = 0; m_miss[i] = 0; end
            m_ptr = 0;
            x0v = 0; x0t = 0; x0s = 0; x1v = 0; x1t = 0; x1s = 0;
        end else begin
            for (int t = 0; t < 4; t++) begin
                int qi, qf;
                qi = int'(iq_int_pos[t*5 +: 5]);
                qf = int'(iq_fp_pos[t*5 +: 5]);
                case (pol_sel)
                    3'd1: key[t] = m_infl[t];
                    3'd2: key[t] = m_br[t];
                    3'd3: key[t] = m_miss[t];
                    3'd4: key[t] = 31 - ((qi < qf) ? qi : qf);
                    default: key[t] = 0;
                endcase
                score[t] = key[t] * 4 + ((t - m_ptr + 4) % 4);
            end
            first = -1; second = -1;
            for (int t = 0; t < 4; t++)
                if (elig_mask[t] && (first < 0 || score[t] < score[first])) first = t;
            for (int t = 0; t < 4; t++)
                if (elig_mask[t] && t != first && (second < 0 || score[t] < score[second])) second = t;
            x0v = 0; x0t = 0; x0s = 0; x1v = 0; x1t = 0; x1s = 0;
            if (first >= 0) begin
                x0v = 1; x0t = first;
                if (second < 0) x0s = 8;
                else begin
                    want = int'(slot_req[first*4 +: 4]);
                    x0s = (want > 8) ? 8 : want;
                    if (8 - x0s > 0) begin x1v = 1; x1t = second; x1s = 8 - x0s; end
                end
                m_ptr = (m_ptr + 1) % 4;
            end
            for (int t = 0; t < 4; t++) begin
                m_infl[t] = bump(m_infl[t], infl_alloc[t], infl_leave[t]);
                m_br[t]   = bump(m_br[t], br_alloc[t], br_leave[t]);
                m_miss[t] = bump(m_miss[t], miss_alloc[t], miss_leave[t]);
            end
        end
    end

    task automatic compare(string tag);
        n_chk++;
        if (int'(f0_vld) != x0v || int'(f0_tid) != x0t || int'(f0_slots) != x0s ||
            int'(f1_vld) != x1v || int'(f1_tid) != x1t || int'(f1_slots) != x1s) begin
            n_fail++;
            $display("FAIL %s: actual v0=%0d t0=%0d s0=%0d v1=%0d t1=%0d s1=%0d expected v0=%0d t0=%0d s0=%0d v1=%0d t1=%0d s1=%0d",
                     tag, f0_vld, f0_tid, f0_slots, f1_vld, f1_tid, f1_slots,
                     x0v, x0t, x0s, x1v, x1t, x1s);
        end
    endtask

    task automatic idle_inputs();
        pol_sel = 3'd0; elig_mask = 4'h0;
        infl_alloc = 0; infl_leave = 0; br_alloc = 0; br_leave = 0;
        miss_alloc = 0; miss_leave = 0;
        iq_int_pos = 0; iq_fp_pos = 0; slot_req = {4{4'd4}};
    endtask

    // pol < 0 picks a random code each cycle; mmode 0 random, 1 one-hot, 2 full.
    task automatic run(string tag, int n, int pol, int mmode, int up_pct, int dn_pct);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            compare(tag);
            pol_sel = (pol < 0) ? 3'($urandom_range(0, 7)) : 3'(pol);
            case (mmode)
                1: elig_mask = 4'(1 << $urandom_range(0, 3));
                2: elig_mask = 4'hF;
                default: elig_mask = 4'($urandom_range(0, 15));
            endcase
            for (int t = 0; t < 4; t++) begin
                infl_alloc[t] = ($urandom_range(0, 99) < up_pct);
                infl_leave[t] = ($urandom_range(0, 99) < dn_pct);
                br_alloc[t]   = ($urandom_range(0, 99) < up_pct);
                br_leave[t]   = ($urandom_range(0, 99) < dn_pct);
                miss_alloc[t] = ($urandom_range(0, 99) < up_pct);
                miss_leave[t] = ($urandom_range(0, 99) < dn_pct);
                iq_int_pos[t*5 +: 5] = 5'($urandom_range(0, 31));
                iq_fp_pos[t*5 +: 5]  = 5'($urandom_range(0, 31));
                slot_req[t*4 +: 4]   = 4'($urandom_range(0, 15));
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; idle_inputs();
        repeat (3) @(negedge clk);
        compare("R1 reset state");
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        idle_inputs();
        do_reset();
        @(negedge clk);
        compare("R1 first cycle after reset");

        run("R6 rotation policy codes", 200, -1, 2, 0, 0);
        run("R6 rotation with masks", 200, 0, 0, 30, 30);
        run("R7 in-flight policy", 400, 1, 2, 55, 40);
        run("R8 branch policy", 400, 2, 0, 50, 45);
        run("R9 miss policy", 400, 3, 2, 45, 50);
        run("R10 queue position policy", 300, 4, 0, 30, 30);
        run("R3 masked threads", 300, -1, 0, 50, 50);
        run("R4 single eligible thread", 150, -1, 1, 50, 50);
        run("R5 slot split", 300, -1, 2, 50, 50);

        do_reset();
        run("R11 equal keys follow pointer", 40, 1, 2, 0, 0);
        run("R2 counters climb past saturation", 120, 1, 2, 90, 5);
        run("R2 counters fall past zero", 120, 1, 2, 5, 90);
        run("R2 balanced strobes", 200, 2, 2, 70, 70);
        run("R12 policy changes every cycle", 300, -1, 0, 50, 45);

        @(negedge clk);
        compare("R12 final");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R12 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule